// File: doc/BRIEF.md
# Emitter Pulse Phase Sequencer

This block drives the switch controls of a capacitor-bank light emitter. Each accepted fire request starts a fixed series of non-overlapping control steps. First the energy harvester is cut off from the supply rail. Next the bank capacitors are taken off their parallel charging rails. Last the bank is switched into a series string that discharges through the emitter. After the discharge width the controls are released in the opposite order, with a dead time between each release. A recharge lockout then keeps the block busy until the bank is full again. All widths and dead times are clock tick counts set by parameters.

The controller is a single state machine with seven states:
- `ST_IDLE`: all controls off, not busy.
- `ST_ISOLATE`: isolate on.
- `ST_UNHOOK`: isolate and unhook on.
- `ST_DISCHARGE`: all three controls on.
- `ST_DROP_SERIES`: series off, isolate and unhook still on.
- `ST_REHOOK`: isolate only.
- `ST_RECHARGE`: all off, still busy.

The normal transitions run IDLE→ISOLATE→UNHOOK→DISCHARGE→DROP_SERIES→REHOOK→RECHARGE→IDLE. There are two abort transitions for when the enable is low at the end of a step: ISOLATE→IDLE, and UNHOOK→REHOOK→IDLE. Fire requests are taken on their rising edge. A rising edge that arrives while the block is busy is dropped and reported as an overrun.

Top module: `emit_phase_seq`

## Requirements
- R1: During reset, and in the cycle right after reset is asserted, `iso_on`, `unhook_on`, `series_on`, `busy` and `overrun` are all 0.
- R2: When a rising edge of `fire_req` is sampled in idle with `arm_en` high, `iso_on` and `busy` go to 1 after that clock edge. `iso_on` is then the only control on for DEAD_TICKS cycles.
- R3: `unhook_on` rises DEAD_TICKS cycles after `iso_on`. `series_on` rises DEAD_TICKS cycles after `unhook_on`. `series_on` is never 1 unless `unhook_on` is 1, and `unhook_on` is never 1 unless `iso_on` is 1.
- R4: `series_on` stays 1 for exactly SERIES_TICKS cycles.
- R5: Release follows the reverse order. `unhook_on` falls DEAD_TICKS cycles after `series_on` falls. `iso_on` falls DEAD_TICKS cycles after `unhook_on` falls. This gives a total isolate width of 4·DEAD_TICKS+SERIES_TICKS cycles.
- R6: `busy` stays 1 for RECHARGE_TICKS cycles after `iso_on` falls. It then drops to 0, and only then is a new request accepted.
- R7: A rising edge of `fire_req` sampled while `busy` is 1 does not change the sequence in progress. `overrun` is 1 for exactly the one cycle after that edge is sampled.
- R8: A request sampled in idle with `arm_en` low is ignored. No control rises, `busy` stays 0 and `overrun` stays 0.
- R9: If `arm_en` is low at the end of the isolate step, `iso_on` drops and the block goes back to idle. If `arm_en` is low at the end of the unhook step, `unhook_on` drops, `iso_on` drops DEAD_TICKS cycles later, and the block goes back to idle. In both cases `series_on` never rises and there is no recharge lockout.
- R10: Once `series_on` is on, lowering `arm_en` does not change the remaining release order, the widths or the recharge lockout.
- R11: If `fire_req` is held high, only one sequence runs. A new sequence needs a new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fire_req | input | 1 | Pulse request, taken on its rising edge |
| arm_en | input | 1 | Enable for starting and continuing a sequence |
| iso_on | output | 1 | Cuts the harvester off from the supply rail |
| unhook_on | output | 1 | Takes the bank off its parallel charging rails |
| series_on | output | 1 | Connects the bank in series through the emitter |
| busy | output | 1 | Sequence or recharge lockout in progress |
| overrun | output | 1 | One-cycle flag for a dropped request |

## Verification
Two events can land in the same clock edge. One is a request edge arriving in the final cycle of the recharge lockout; the other is the return to idle that would accept that request. The bench raises `fire_req` so that it is sampled in the last busy cycle. The expected result is an overrun and no new sequence. A second check raises the request one cycle later, with the block idle, and expects a clean new pulse. Separately, `arm_en` is lowered so that it is sampled exactly at the end of the isolate step and exactly at the end of the unhook step. At each of these points the bench checks, cycle by cycle, that the abort release path is taken and that the series control never rises.

// File: rtl/emit_seq_pkg.sv
package emit_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE        = 3'd0,
        ST_ISOLATE     = 3'd1,
        ST_UNHOOK      = 3'd2,
        ST_DISCHARGE   = 3'd3,
        ST_DROP_SERIES = 3'd4,
        ST_REHOOK      = 3'd5,
        ST_RECHARGE    = 3'd6
    } seq_state_t;

endpackage

// File: rtl/phase_timer.sv
// Down-counter that sets how long each step lasts. It is loaded on every
// state change. expired is high in the last cycle of the step.
module phase_timer #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/req_gate.sv
// Finds the rising edge of the request and flags edges that arrive while busy.
module req_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_req,
    input  logic busy,
    output logic rise,
    output logic overrun
);
    logic req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            overrun <= 1'b0;
        end else begin
            req_q   <= fire_req;
            overrun <= rise && busy;
        end
    end

    assign rise = fire_req && !req_q;
endmodule

// File: rtl/emit_phase_seq.sv
module emit_phase_seq
    import emit_seq_pkg::*;
#(
    parameter int DEAD_TICKS     = 2,
    parameter int SERIES_TICKS   = 4,
    parameter int RECHARGE_TICKS = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_req,
    input  logic arm_en,
    output logic iso_on,
    output logic unhook_on,
    output logic series_on,
    output logic busy,
    output logic overrun
);
    localparam int MAX_A = (DEAD_TICKS > SERIES_TICKS) ? DEAD_TICKS : SERIES_TICKS;
    localparam int MAX_T = (MAX_A > RECHARGE_TICKS) ? MAX_A : RECHARGE_TICKS;
    localparam int CW    = $clog2(MAX_T + 1);

    localparam logic [CW-1:0] LD_DEAD   = CW'(DEAD_TICKS - 1);
    localparam logic [CW-1:0] LD_SERIES = CW'(SERIES_TICKS - 1);
    localparam logic [CW-1:0] LD_RECHG  = CW'(RECHARGE_TICKS - 1);

    seq_state_t    state, nxt;
    logic          fired;
    logic          rise;
    logic          expired;
    logic          load;
    logic [CW-1:0] load_val;

    req_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_req(fire_req),
        .busy    (busy),
        .rise    (rise),
        .overrun (overrun)
    );

    phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .load_val(load_val),
        .expired (expired)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:        if (rise && arm_en) nxt = ST_ISOLATE;
            ST_ISOLATE:     if (expired) nxt = arm_en ? ST_UNHOOK : ST_IDLE;
            ST_UNHOOK:      if (expired) nxt = arm_en ? ST_DISCHARGE : ST_REHOOK;
            ST_DISCHARGE:   if (expired) nxt = ST_DROP_SERIES;
            ST_DROP_SERIES: if (expired) nxt = ST_REHOOK;
            ST_REHOOK:      if (expired) nxt = fired ? ST_RECHARGE : ST_IDLE;
            ST_RECHARGE:    if (expired) nxt = ST_IDLE;
            default:        nxt = ST_IDLE;
        endcase
    end

    // Step length for the state being entered
    always_comb begin
        load = (nxt != state);
        unique case (nxt)
            ST_DISCHARGE: load_val = LD_SERIES;
            ST_RECHARGE:  load_val = LD_RECHG;
            ST_IDLE:      load_val = '0;
            default:      load_val = LD_DEAD;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            fired <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == ST_DISCHARGE) begin
                fired <= 1'b1;
            end else if (nxt == ST_IDLE) begin
                fired <= 1'b0;
            end
        end
    end

    // Output decode
    always_comb begin
        iso_on    = 1'b0;
        unhook_on = 1'b0;
        series_on = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE:        busy = 1'b0;
            ST_ISOLATE:     iso_on = 1'b1;
            ST_UNHOOK:      begin iso_on = 1'b1; unhook_on = 1'b1; end
            ST_DISCHARGE:   begin iso_on = 1'b1; unhook_on = 1'b1; series_on = 1'b1; end
            ST_DROP_SERIES: begin iso_on = 1'b1; unhook_on = 1'b1; end
            ST_REHOOK:      iso_on = 1'b1;
            ST_RECHARGE:    ;
            default:        busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/emit_phase_seq_chk.sv
module emit_phase_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic iso_on,
    input logic unhook_on,
    input logic series_on,
    input logic busy,
    input logic overrun
);
    p_series_nest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        series_on |-> (unhook_on && iso_on));

    p_unhook_nest_r3: assert property (@(posedge clk) disable iff (!rst_n)
        unhook_on |-> iso_on);

    p_series_after_unhook_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(series_on) |-> $past(unhook_on));

    p_unhook_after_iso_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unhook_on) |-> $past(iso_on));

    p_iso_last_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso_on) |-> (!unhook_on && !$past(unhook_on)));

    p_unhook_after_series_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unhook_on) |-> (!series_on && !$past(series_on)));

    p_iso_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iso_on |-> busy);

    p_overrun_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(busy));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!iso_on && !unhook_on && !series_on));
endmodule

bind emit_phase_seq emit_phase_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .iso_on   (iso_on),
    .unhook_on(unhook_on),
    .series_on(series_on),
    .busy     (busy),
    .overrun  (overrun)
);

// File: tb/emit_phase_seq_test.sv
module emit_phase_seq_test;
    localparam int CLK_NS = 10;
    localparam int D      = 2;
    localparam int S      = 4;
    localparam int R      = 30;
    localparam int ISO_W  = 4 * D + S;
    localparam int TOTAL  = ISO_W + R;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fire_req = 1'b0;
    logic arm_en = 1'b1;
    logic iso_on, unhook_on, series_on, busy, overrun;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_NS / 2) clk = ~clk;

    emit_phase_seq #(.DEAD_TICKS(D), .SERIES_TICKS(S), .RECHARGE_TICKS(R)) uut (
        .clk(clk), .rst_n(rst_n), .fire_req(fire_req), .arm_en(arm_en),
        .iso_on(iso_on), .unhook_on(unhook_on), .series_on(series_on),
        .busy(busy), .overrun(overrun)
    );

    // Bit order: {iso, unhook, series, busy, overrun}
    task automatic chk(input string req, input int k, input logic [4:0] exp);
        logic [4:0] act;
        act = {iso_on, unhook_on, series_on, busy, overrun};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s k=%0d actual=%b expected=%b", req, k, act, exp);
        end
    endtask

    // k counts samples after the accepting edge.
    // mode 0 = full pulse, 1 = abort at end of isolate, 2 = abort at end of unhook.
    function automatic logic [4:0] expv(int k, int mode, int inj);
        logic iso, unh, ser, bsy, ov;
        int bend;
        case (mode)
            1: begin
                iso = k < D; unh = 1'b0; ser = 1'b0; bend = D;
            end
            2: begin
                iso = k < 3 * D; unh = (k >= D) && (k < 2 * D); ser = 1'b0; bend = 3 * D;
            end
            default: begin
                iso = k < ISO_W;
                unh = (k >= D) && (k < 3 * D + S);
                ser = (k >= 2 * D) && (k < 2 * D + S);
                bend = TOTAL;
            end
        endcase
        bsy = k < bend;
        ov  = (inj > 0) && (inj < bend) && (k == inj + 1);
        return {iso, unh, ser, bsy, ov};
    endfunction

    task automatic run_seq(input string req, input int inj, input int drop_k,
                           input int mode, input int post);
        int span;
        span = ((mode == 1) ? D : (mode == 2) ? 3 * D : TOTAL) + post;
        @(negedge clk);
        fire_req = 1'b1;
        for (int k = 0; k < span; k++) begin
            @(negedge clk);
            fire_req = (k == inj);
            if (k == drop_k) arm_en = 1'b0;
            chk(req, k, expv(k, mode, inj));
        end
        fire_req = 1'b0;
        arm_en   = 1'b1;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1", 0, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 1, 5'b0);
    endtask

    task automatic t_basic;
        run_seq("R2 R3 R4 R5 R6", -1, -1, 0, 3);
    endtask

    task automatic t_overrun_mid;
        run_seq("R7", 10, -1, 0, 2);
    endtask

    task automatic t_overrun_edge;
        // Request sampled in the last lockout cycle is dropped, no new pulse
        run_seq("R6 R7", TOTAL - 1, -1, 0, 4);
        // One cycle later the same kind of request is accepted
        run_seq("R6 R2", -1, -1, 0, 1);
    endtask

    task automatic t_disabled;
        arm_en = 1'b0;
        @(negedge clk);
        fire_req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            fire_req = 1'b0;
            chk("R8", k, 5'b0);
        end
        arm_en = 1'b1;
    endtask

    task automatic t_abort;
        run_seq("R9 isolate", -1, 0, 1, 3);
        run_seq("R9 unhook", -1, D, 2, 3);
    endtask

    task automatic t_late_drop;
        run_seq("R10", -1, 2 * D, 0, 2);
    endtask

    task automatic t_held;
        @(negedge clk);
        fire_req = 1'b1;
        for (int k = 0; k < TOTAL + 5; k++) begin
            @(negedge clk);
            chk("R11", k, expv(k, 0, -1));
        end
        fire_req = 1'b0;
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        fire_req = 1'b1;
        repeat (6) @(negedge clk);
        fire_req = 1'b0;
        rst_n = 1'b0;
        #1;
        chk("R1 mid", 0, 5'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 mid", 1, 5'b0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=hung expected=done");
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_overrun_mid();
        t_overrun_edge();
        t_disabled();
        t_abort();
        t_late_drop();
        t_held();
        t_reset_mid();
        t_basic();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule